// File: doc/BRIEF.md
# Pixel PLL Divisor Search Engine

This block picks integer divisor settings for a pixel clock synthesiser fed by a fixed 120 MHz reference. A host gives it a requested pixel clock in kHz and a flag that says whether the panel link is dual-channel. It then walks every candidate pair of post divider P1 and input divider N. For each pair it computes the feedback multiplier M that best matches the target, throws away any M outside the usable range, and measures how far the achieved frequency lands from the target. The closest setting wins.

When the walk is over, the engine splits the winning M into a coarse part and a fine part, M = 5·M1 + M2. It packs N, M1 and M2 into one divisor word and also gives P1 as a one-hot field. If no candidate is usable, it raises a fail flag. Every division goes through one shared, multi-cycle restoring divider, so a search takes a few thousand clock cycles.

The control is a state machine with these states:
- `S_IDLE` waits for `start`.
- `S_MDIV` launches the M division, and `S_MWAIT` waits for its result.
- `S_RANGE` checks M against the usable range.
- `S_FDIV` launches the frequency division, and `S_FWAIT` waits for its result.
- `S_EVAL` compares the error with the best so far.
- `S_STEP` advances to the next candidate.
- `S_DONE` publishes the result.

The transitions are:
- IDLE→MDIV on start.
- MDIV→MWAIT at once.
- MWAIT→RANGE when the divider answers.
- RANGE→FDIV when M is in range, and RANGE→STEP when it is not.
- FDIV→FWAIT at once.
- FWAIT→EVAL when the divider answers.
- EVAL→STEP at once.
- STEP→MDIV while candidates remain, and STEP→DONE after the last one.
- DONE→IDLE at once.

Top module: `pll_div_search`

## Requirements
- R1: The effective target is twice `pix_khz` when `dual_ch` is 0, and equals `pix_khz` when `dual_ch` is 1.
- R2: Candidates are visited with P1 from 1 to 8 in the outer loop and N from 5 to 10 in the inner loop. The best setting is replaced only by a strictly smaller error, so on a tie the earliest candidate is kept.
- R3: For each candidate, denom = N·P1·7 and M = floor((target·denom + 60000) / 120000). A candidate with M < 77 or M > 131 is skipped.
- R4: The achieved frequency is floor(120000·M / denom), and the error is the absolute difference between it and the target.
- R5: The winning M is split as M2 = ((M+3) mod 5) + 7 and M1 = (M − M2)/5, so M2 always lies in 7..11.
- R6: `div_word` holds N−2 in bits 23:16, M1−2 in bits 15:8 and M2 in bits 7:0. Bits 31:24 are zero.
- R7: `p1_onehot` has bit P1−1 set and no other bit set.
- R8: When no candidate passes the range check, `fail` is 1, and both `div_word` and `p1_onehot` are 0.
- R9: `busy` is high from the cycle after an accepted start until the result is published. `done` is a one-cycle pulse, and the result outputs change only in the cycle `done` is high.
- R10: A `start` that arrives while `busy` is high is ignored. The running search finishes with its original inputs.
- R11: After reset, `busy`, `done`, `fail`, `div_word` and `p1_onehot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search when idle |
| dual_ch | input | 1 | 1 = dual-channel link, 0 = single-channel link |
| pix_khz | input | 32 | Requested pixel clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is published |
| fail | output | 1 | No usable divisor was found |
| div_word | output | 32 | Packed N, M1 and M2 fields |
| p1_onehot | output | 8 | One-hot P1 |

## Verification
`busy` is due one cycle after the edge that samples `start`. The bench checks it on the next falling edge. The results are due in the cycle `done` is high, which comes thousands of cycles later, depending on how many candidates pass the range check. So the bench polls `done` on falling edges under a bounded wait, and reads `div_word`, `p1_onehot` and `fail` in that same half-cycle. One cycle later it samples again, to confirm that `done` has dropped and that the result is still held. The expected words come from a bench model of the search written from the requirements.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MDIV,
        S_MWAIT,
        S_RANGE,
        S_FDIV,
        S_FWAIT,
        S_EVAL,
        S_STEP,
        S_DONE
    } srch_state_t;

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
    parameter int DW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          vld,
    output logic [DW-1:0] quo
);
    localparam int CNT_W = $clog2(DW + 1);

    logic [DW-1:0]  rem_q, quo_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic           run_q, vld_q;
    logic [DW:0]    trial, diff;
    logic           ge;

    // one restoring step per cycle, quotient bits shift in from the right
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        diff  = trial - {1'b0, den_q};
        ge    = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CNT_W'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= ge ? diff[DW-1:0] : trial[DW-1:0];
                quo_q <= {quo_q[DW-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    vld_q <= 1'b1;
                end
            end
        end
    end

    assign vld = vld_q;
    assign quo = quo_q;
endmodule

// File: rtl/pll_field_pack.sv
module pll_field_pack #(
    parameter int MW   = 8,
    parameter int CW   = 4,
    parameter int OH_W = 8
) (
    input  logic [MW-1:0]   m_val,
    input  logic [CW-1:0]   n_val,
    input  logic [CW-1:0]   p1_val,
    output logic [31:0]     word,
    output logic [OH_W-1:0] onehot
);
    logic [7:0] m2_f, m1_f, n_f;

    always_comb begin
        m2_f = 8'(((32'(m_val) + 32'd3) % 32'd5) + 32'd7);
        m1_f = 8'((32'(m_val) - 32'(m2_f)) / 32'd5);
        n_f  = 8'(n_val);
        word = {8'h00, n_f - 8'd2, m1_f - 8'd2, m2_f};
    end

    for (genvar k = 0; k < OH_W; k++) begin : g_oh
        assign onehot[k] = (p1_val == CW'(k + 1));
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_srch_pkg::*;
#(
    parameter int PIX_W   = 32,
    parameter int DW      = 40,
    parameter int REF_KHZ = 120000,
    parameter int POST_K  = 7,
    parameter int P1_LO   = 1,
    parameter int P1_HI   = 8,
    parameter int N_LO    = 5,
    parameter int N_HI    = 10,
    parameter int M_LO    = 77,
    parameter int M_HI    = 131
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dual_ch,
    input  logic [PIX_W-1:0] pix_khz,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [31:0]      div_word,
    output logic [P1_HI-1:0] p1_onehot
);
    localparam int CW       = $clog2((P1_HI > N_HI ? P1_HI : N_HI) + 1);
    localparam int MW       = $clog2(M_HI + 1);
    localparam int HALF_REF = REF_KHZ / 2;

    srch_state_t state_q, state_d;

    logic [DW-1:0]    target_q, m_q, freq_q, best_err_q, err;
    logic [CW-1:0]    p1_q, n_q, best_p1_q, best_n_q;
    logic [MW-1:0]    best_m_q;
    logic [DW-1:0]    denom, div_num, div_den, div_quo;
    logic             div_go, div_vld, m_ok, last_cand;
    logic [31:0]      pk_word;
    logic [P1_HI-1:0] pk_oh;
    logic             done_q, fail_q;
    logic [31:0]      word_q;
    logic [P1_HI-1:0] oh_q;

    assign denom     = DW'(n_q) * DW'(p1_q) * DW'(POST_K);
    assign m_ok      = (m_q >= DW'(M_LO)) && (m_q <= DW'(M_HI));
    assign last_cand = (p1_q == CW'(P1_HI)) && (n_q == CW'(N_HI));
    assign err       = (target_q > freq_q) ? (target_q - freq_q) : (freq_q - target_q);
    assign div_go    = (state_q == S_MDIV) || (state_q == S_FDIV);
    assign div_num   = (state_q == S_MDIV) ? (target_q * denom + DW'(HALF_REF))
                                           : (DW'(REF_KHZ) * m_q);
    assign div_den   = (state_q == S_MDIV) ? DW'(REF_KHZ) : denom;

    pll_seq_divider #(.DW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .vld   (div_vld),
        .quo   (div_quo)
    );

    pll_field_pack #(.MW(MW), .CW(CW), .OH_W(P1_HI)) u_pack (
        .m_val  (best_m_q),
        .n_val  (best_n_q),
        .p1_val (best_p1_q),
        .word   (pk_word),
        .onehot (pk_oh)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_MDIV;
            S_MDIV:  state_d = S_MWAIT;
            S_MWAIT: if (div_vld) state_d = S_RANGE;
            S_RANGE: state_d = m_ok ? S_FDIV : S_STEP;
            S_FDIV:  state_d = S_FWAIT;
            S_FWAIT: if (div_vld) state_d = S_EVAL;
            S_EVAL:  state_d = S_STEP;
            S_STEP:  state_d = last_cand ? S_DONE : S_MDIV;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q   <= '0;
            m_q        <= '0;
            freq_q     <= '0;
            best_err_q <= '1;
            p1_q       <= CW'(P1_LO);
            n_q        <= CW'(N_LO);
            best_p1_q  <= CW'(P1_LO);
            best_n_q   <= CW'(N_LO);
            best_m_q   <= '0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            word_q     <= '0;
            oh_q       <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    target_q   <= dual_ch ? DW'(pix_khz) : (DW'(pix_khz) << 1);
                    p1_q       <= CW'(P1_LO);
                    n_q        <= CW'(N_LO);
                    best_err_q <= '1;
                end
                S_MWAIT: if (div_vld) m_q <= div_quo;
                S_FWAIT: if (div_vld) freq_q <= div_quo;
                S_EVAL: if (err < best_err_q) begin
                    best_err_q <= err;
                    best_m_q   <= m_q[MW-1:0];
                    best_n_q   <= n_q;
                    best_p1_q  <= p1_q;
                end
                S_STEP: if (!last_cand) begin
                    if (n_q == CW'(N_HI)) begin
                        n_q  <= CW'(N_LO);
                        p1_q <= p1_q + 1'b1;
                    end else begin
                        n_q <= n_q + 1'b1;
                    end
                end
                S_DONE: begin
                    done_q <= 1'b1;
                    fail_q <= (best_err_q == '1);
                    word_q <= (best_err_q == '1) ? '0 : pk_word;
                    oh_q   <= (best_err_q == '1) ? '0 : pk_oh;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;
    assign div_word  = word_q;
    assign p1_onehot = oh_q;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int OH_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            fail,
    input logic [31:0]     div_word,
    input logic [OH_W-1:0] p1_onehot
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_word) |-> done); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R10
    AST_P1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> ($countones(p1_onehot) == 1)); // R7
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (div_word == 32'd0 && p1_onehot == '0)); // R8
    AST_M2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (div_word[7:0] >= 8'd7 && div_word[7:0] <= 8'd11)); // R5
    AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_word[31:24] == 8'd0)); // R6
endmodule

bind pll_div_search pll_div_search_chk #(.OH_W(P1_HI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .div_word  (div_word),
    .p1_onehot (p1_onehot)
);

// File: tb/tb_pll_div_search.sv
`timescale 1ns/1ps
module tb_pll_div_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dual_ch = 1'b0;
    logic [31:0] pix_khz = '0;
    logic        busy, done, fail;
    logic [31:0] div_word;
    logic [7:0]  p1_onehot;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    pll_div_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dual_ch(dual_ch),
        .pix_khz(pix_khz), .busy(busy), .done(done), .fail(fail),
        .div_word(div_word), .p1_onehot(p1_onehot)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Search model built from R1..R8
    function automatic void model(input longint unsigned pix, input bit dual,
                                  output logic [31:0] w, output logic [7:0] oh, output bit f);
        longint unsigned tgt, den, m, fr, e, best;
        int bn, bp, bm, m2, m1;
        tgt  = dual ? pix : 2 * pix;                    // R1
        best = 64'hFFFF_FFFF_FFFF_FFFF;
        bn = 0; bp = 0; bm = 0;
        for (int p = 1; p <= 8; p++) begin              // R2
            for (int n = 5; n <= 10; n++) begin
                den = longint'(n * p * 7);
                m = (tgt * den + 60000) / 120000;      // R3
                if (m < 77 || m > 131) continue;
                fr = (120000 * m) / den;                // R4
                e = (tgt > fr) ? tgt - fr : fr - tgt;
                if (e < best) begin best = e; bn = n; bp = p; bm = int'(m); end
            end
        end
        f = (best == 64'hFFFF_FFFF_FFFF_FFFF);
        if (f) begin w = '0; oh = '0; end
        else begin
            m2 = ((bm + 3) % 5) + 7;                    // R5
            m1 = (bm - m2) / 5;
            w  = {8'h00, 8'(bn - 2), 8'(m1 - 2), 8'(m2)}; // R6
            oh = 8'(1 << (bp - 1));                     // R7
        end
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic launch(input logic [31:0] pix, input bit dual);
        @(negedge clk);
        pix_khz = pix; dual_ch = dual; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", 32'(busy), 32'd1);
    endtask

    task automatic check_result(input logic [31:0] pix, input bit dual, input string tag);
        logic [31:0] ew; logic [7:0] eo; bit ef; bit seen;
        logic [31:0] w_hold;
        model(longint'(pix), dual, ew, eo, ef);
        wait_done(seen);
        chk(seen, {tag, " R9 done arrives"}, 32'(seen), 32'd1);
        chk(fail == ef, {tag, " R8 fail flag"}, 32'(fail), 32'(ef));
        chk(div_word == ew, {tag, " R6 R5 R3 R2 divisor word"}, div_word, ew);
        chk(p1_onehot == eo, {tag, " R7 p1 one-hot"}, 32'(p1_onehot), 32'(eo));
        w_hold = div_word;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done single pulse"}, 32'(done), 32'd0);
        chk(div_word == w_hold, {tag, " R9 result held"}, div_word, w_hold);
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0 && fail == 0, "R11 reset flags", {29'd0, busy, done, fail}, 32'd0);
        chk(div_word == 0 && p1_onehot == 0, "R11 reset outputs", div_word | 32'(p1_onehot), 32'd0);
    endtask

    task automatic t_single_65mhz;     // R1 single-channel doubling
        launch(32'd65000, 1'b0);
        check_result(32'd65000, 1'b0, "single 65000 R1");
    endtask

    task automatic t_dual_108mhz;
        launch(32'd108000, 1'b1);
        check_result(32'd108000, 1'b1, "dual 108000 R1 R4");
    endtask

    task automatic t_single_25mhz;
        launch(32'd25175, 1'b0);
        check_result(32'd25175, 1'b0, "single 25175 R4");
    endtask

    task automatic t_fail_low;         // R8 nothing reaches M of 77
        launch(32'd1000, 1'b1);
        check_result(32'd1000, 1'b1, "low target R8 R3");
    endtask

    task automatic t_fail_high;        // R8 every M above 131
        launch(32'd3000000, 1'b0);
        check_result(32'd3000000, 1'b0, "high target R8 R3");
    endtask

    task automatic t_ignore_start;     // R10
        launch(32'd54000, 1'b1);
        repeat (10) @(negedge clk);
        pix_khz = 32'd162000; dual_ch = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 still busy after ignored start", 32'(busy), 32'd1);
        check_result(32'd54000, 1'b1, "R10 original inputs kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_65mhz();
        t_dual_108mhz();
        t_single_25mhz();
        t_fail_low();
        t_fail_high();
        t_ignore_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule